// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits at the end of a cable receiver's decoding chain. It takes decoded 188-byte transport packets one byte at a time. Each packet arrives with a start-of-packet marker on its first byte (the 0x47 sync byte) and an uncorrectable flag that applies to the whole packet. The block presents the stream on an 8-bit output bus in either a parallel or a serial format, selected by a mode input. Alongside the data it drives an output clock enable, a data-valid strobe, a packet-sync pulse and an uncorrectable-packet indicator.

When a packet is flagged uncorrectable, the block passes its bytes through unchanged with one exception. It sets the most significant bit of the byte that follows the sync byte, which is the transport error indicator, so that a downstream demultiplexer discards the packet. A configuration input turns this marking off.

In serial mode each byte is sent MSB first on bit 0 of the bus. Every bit is held for a parameterised number of clock cycles, and the block stalls its input while a byte is still being shifted out. The mode select is expected to change only while the block is held in reset.

Top module: `ts_stream_fmt`

## Requirements
- R1: With `ser_mode`=0 the whole byte appears on `ts_data[7:0]`. With `ser_mode`=1 the current bit appears on `ts_data[0]`, and `ts_data[7:1]` is 0 whenever `ts_den` is high.
- R2: In parallel mode `in_ready` is always 1. A byte accepted in one cycle is shown in the next cycle with `ts_den` and `ts_ce` both high. Cycles with no accepted byte give `ts_den`=`ts_ce`=0.
- R3: In parallel mode `ts_psync` is high only in the output cycle of a byte that was accepted with `in_sop`=1.
- R4: In serial mode `ts_psync` is high for every cycle of the first (most significant) bit of a byte accepted with `in_sop`=1, and low for its other seven bits.
- R5: `in_uncor` is sampled only on a byte with `in_sop`=1 and applies to that packet. `ts_uncor` is high for every output cycle of every byte of a flagged packet and low for all other cycles.
- R6: For a flagged packet with `tei_off`=0, the byte at index 1 (the byte after the sync byte) is output with bit 7 forced to 1. Every other byte is output unchanged.
- R7: With `tei_off`=1, bytes of flagged packets are output unchanged.
- R8: In serial mode bits go out MSB first. Each bit is held for `SER_DIV` cycles with `ts_den` high throughout, and `ts_ce` is high only in the first cycle of each bit.
- R9: In serial mode `in_ready` is high only when no bit of an earlier byte remains to be sent. Bytes offered back to back therefore give a gap-free `ts_den`.
- R10: A byte with `in_sop`=1 restarts the byte index at 0 even inside a packet. The index stops at `PKT_BYTES`-1, so overlong packets are never marked a second time. Bytes received before the first start-of-packet are never marked.
- R11: While `rst` is high, and in the first cycle after it, `ts_den`, `ts_ce`, `ts_psync` and `ts_uncor` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | 0 = parallel byte output, 1 = serial MSB-first output |
| tei_off | input | 1 | 1 = do not set the error indicator in flagged packets |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is the first (sync) byte of a packet |
| in_uncor | input | 1 | Packet is uncorrectable; sampled with `in_sop` |
| ts_data | output | 8 | Output byte, or serial bit on bit 0 |
| ts_ce | output | 1 | Output clock enable, one pulse per new byte or bit |
| ts_den | output | 1 | Output data valid |
| ts_psync | output | 1 | Packet sync pulse |
| ts_uncor | output | 1 | Uncorrectable packet indicator |

## Verification
The error-indicator marking and the packet-boundary tracking can act on bytes only one apart. In some cycles a start-of-packet arrives just after, or just before, the byte at index 1. The flag of the new packet and the marking decision for its index-1 byte must then both follow the new packet. To provoke this, the bench sends one-byte and two-byte packets with alternating uncorrectable flags back to back, in both modes. It also sends a packet longer than 188 bytes and a stream with no leading start-of-packet. A behavioural queue model predicts data, sync, flag, clock enable and ready for every cycle, and the bench compares the outputs against it every cycle.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;
  localparam int BYTE_W = 8;

  // one byte on its way to an output driver, already marked
  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              sync;
    logic              uncor;
  } ts_beat_t;
endpackage

// File: rtl/ts_fmt_mark.sv
module ts_fmt_mark
  import ts_fmt_pkg::*;
#(
  parameter int PKT_BYTES = 188,
  parameter int TEI_IDX   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_uncor,
  input  logic              tei_off,
  output ts_beat_t          beat
);
  localparam int IW = $clog2(PKT_BYTES);
  localparam logic [IW-1:0] LAST = IW'(PKT_BYTES - 1);
  localparam logic [IW-1:0] MARK = IW'(TEI_IDX);

  logic [IW-1:0] idx_q;
  logic          unc_q;
  logic [IW-1:0] idx_now;
  logic          unc_now;
  logic          mark_now;

  // position and flag of the byte being offered now
  always_comb begin
    if (in_sop) begin
      idx_now = '0;
      unc_now = in_uncor;
    end else begin
      idx_now = (idx_q == LAST) ? LAST : idx_q + 1'b1;
      unc_now = unc_q;
    end
    mark_now = unc_now && !tei_off && (idx_now == MARK);
    beat.data  = in_data | {mark_now, {(BYTE_W-1){1'b0}}};
    beat.sync  = in_sop;
    beat.uncor = unc_now;
  end

  // idle at the saturated index so nothing is marked before a first sync
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= LAST;
      unc_q <= 1'b0;
    end else if (fire) begin
      idx_q <= idx_now;
      unc_q <= unc_now;
    end
  end

  p_idx_range_r10: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST);

  p_flag_latch_r5: assert property (@(posedge clk) disable iff (rst)
    fire && in_sop |=> unc_q == $past(in_uncor));

  p_no_mark_r7: assert property (@(posedge clk) disable iff (rst)
    fire && tei_off |-> beat.data == in_data);
endmodule

// File: rtl/ts_fmt_par.sv
module ts_fmt_par
  import ts_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  ts_beat_t          beat,
  output logic [BYTE_W-1:0] data_o,
  output logic              den_o,
  output logic              ce_o,
  output logic              psync_o,
  output logic              uncor_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      den_o   <= 1'b0;
      ce_o    <= 1'b0;
      psync_o <= 1'b0;
      uncor_o <= 1'b0;
    end else begin
      den_o   <= fire;
      ce_o    <= fire;
      psync_o <= fire && beat.sync;
      uncor_o <= fire && beat.uncor;
      if (fire) data_o <= beat.data;
    end
  end

  p_par_ce_den_r2: assert property (@(posedge clk) disable iff (rst)
    den_o |-> ce_o);

  p_par_sync_r3: assert property (@(posedge clk) disable iff (rst)
    psync_o |-> $past(fire) && den_o);
endmodule

// File: rtl/ts_fmt_ser.sv
module ts_fmt_ser
  import ts_fmt_pkg::*;
#(
  parameter int SER_DIV = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     fire,
  input  ts_beat_t beat,
  output logic     idle_o,
  output logic     bit_o,
  output logic     den_o,
  output logic     ce_o,
  output logic     psync_o,
  output logic     uncor_o
);
  localparam int BW = $clog2(BYTE_W);
  localparam int DW = (SER_DIV > 1) ? $clog2(SER_DIV) : 1;
  localparam logic [DW-1:0] DTOP = DW'(SER_DIV - 1);
  localparam logic [BW-1:0] BTOP = BW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [BW-1:0]     bcnt_q;
  logic [DW-1:0]     dcnt_q;

  assign idle_o = (bcnt_q == '0) && (dcnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      bcnt_q  <= '0;
      dcnt_q  <= '0;
      bit_o   <= 1'b0;
      den_o   <= 1'b0;
      ce_o    <= 1'b0;
      psync_o <= 1'b0;
      uncor_o <= 1'b0;
    end else if (fire) begin
      bit_o   <= beat.data[BYTE_W-1];
      sh_q    <= {beat.data[BYTE_W-2:0], 1'b0};
      bcnt_q  <= BTOP;
      dcnt_q  <= DTOP;
      den_o   <= 1'b1;
      ce_o    <= 1'b1;
      psync_o <= beat.sync;
      uncor_o <= beat.uncor;
    end else if (dcnt_q != '0) begin
      dcnt_q <= dcnt_q - 1'b1;
      ce_o   <= 1'b0;
    end else if (bcnt_q != '0) begin
      bit_o   <= sh_q[BYTE_W-1];
      sh_q    <= {sh_q[BYTE_W-2:0], 1'b0};
      bcnt_q  <= bcnt_q - 1'b1;
      dcnt_q  <= DTOP;
      ce_o    <= 1'b1;
      psync_o <= 1'b0;
    end else begin
      den_o   <= 1'b0;
      ce_o    <= 1'b0;
      psync_o <= 1'b0;
      uncor_o <= 1'b0;
    end
  end

  p_ser_hold_r8: assert property (@(posedge clk) disable iff (rst)
    den_o && !ce_o |-> bit_o == $past(bit_o));

  p_ser_load_idle_r9: assert property (@(posedge clk) disable iff (rst)
    fire |-> !den_o || (bcnt_q == '0 && dcnt_q == '0));
endmodule

// File: rtl/ts_stream_fmt.sv
module ts_stream_fmt
  import ts_fmt_pkg::*;
#(
  parameter int PKT_BYTES = 188,
  parameter int SER_DIV   = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ser_mode,
  input  logic        tei_off,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sop,
  input  logic        in_uncor,
  output logic [7:0]  ts_data,
  output logic        ts_ce,
  output logic        ts_den,
  output logic        ts_psync,
  output logic        ts_uncor
);
  ts_beat_t          beat;
  logic              fire;
  logic              ser_idle;
  logic [BYTE_W-1:0] par_data;
  logic              par_den, par_ce, par_ps, par_un;
  logic              ser_bit, ser_den, ser_ce, ser_ps, ser_un;

  assign in_ready = ser_mode ? ser_idle : 1'b1;
  assign fire     = in_valid && in_ready;

  ts_fmt_mark #(.PKT_BYTES(PKT_BYTES), .TEI_IDX(1)) u_mark (
    .clk(clk), .rst(rst), .fire(fire), .in_data(in_data), .in_sop(in_sop),
    .in_uncor(in_uncor), .tei_off(tei_off), .beat(beat)
  );

  ts_fmt_par u_par (
    .clk(clk), .rst(rst), .fire(fire && !ser_mode), .beat(beat),
    .data_o(par_data), .den_o(par_den), .ce_o(par_ce),
    .psync_o(par_ps), .uncor_o(par_un)
  );

  ts_fmt_ser #(.SER_DIV(SER_DIV)) u_ser (
    .clk(clk), .rst(rst), .fire(fire && ser_mode), .beat(beat),
    .idle_o(ser_idle), .bit_o(ser_bit), .den_o(ser_den), .ce_o(ser_ce),
    .psync_o(ser_ps), .uncor_o(ser_un)
  );

  always_comb begin
    if (ser_mode) begin
      ts_data  = {{(BYTE_W-1){1'b0}}, ser_bit};
      ts_ce    = ser_ce;
      ts_den   = ser_den;
      ts_psync = ser_ps;
      ts_uncor = ser_un;
    end else begin
      ts_data  = par_data;
      ts_ce    = par_ce;
      ts_den   = par_den;
      ts_psync = par_ps;
      ts_uncor = par_un;
    end
  end

  p_psync_den_r3: assert property (@(posedge clk) disable iff (rst)
    ts_psync |-> ts_den);

  p_uncor_den_r5: assert property (@(posedge clk) disable iff (rst)
    ts_uncor |-> ts_den);

  p_ce_den_r8: assert property (@(posedge clk) disable iff (rst)
    ts_ce |-> ts_den);

  p_reset_quiet_r11: assert property (@(posedge clk)
    $past(rst) |-> !ts_den && !ts_ce && !ts_psync && !ts_uncor);
endmodule

// File: tb/ts_stream_fmt_test.sv
module ts_stream_fmt_test;
  localparam int PKT = 188;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_mode = 1'b0;
  logic       tei_off = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_sop = 1'b0;
  logic       in_uncor = 1'b0;
  logic [7:0] ts_data;
  logic       ts_ce, ts_den, ts_psync, ts_uncor;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R2";

  typedef struct packed {logic [7:0] d; logic ce; logic ps; logic un;} exp_t;
  exp_t q[$];
  int   m_idx = PKT - 1;
  bit   m_unc = 1'b0;
  logic [7:0] ex_d;
  logic ex_den, ex_ce, ex_ps, ex_un;

  always #10 clk = ~clk;

  ts_stream_fmt #(.PKT_BYTES(PKT), .SER_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .tei_off(tei_off),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_uncor(in_uncor), .ts_data(ts_data), .ts_ce(ts_ce),
    .ts_den(ts_den), .ts_psync(ts_psync), .ts_uncor(ts_uncor)
  );

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", what, act, exp, $time);
    end
  endtask

  task automatic model(bit acc, logic [7:0] d, bit sop, bit unc);
    logic [7:0] b;
    if (acc) begin
      if (sop) begin m_idx = 0; m_unc = unc; end
      else if (m_idx < PKT - 1) m_idx++;
      b = d;
      if (m_idx == 1 && m_unc && !tei_off) b[7] = 1'b1;
      if (!ser_mode) q.push_back({b, 1'b1, sop, m_unc});
      else
        for (int k = 7; k >= 0; k--)
          for (int c = 0; c < DIV; c++)
            q.push_back({7'd0, b[k], c == 0, sop && k == 7, m_unc});
    end
    if (q.size() > 0) begin
      exp_t e = q.pop_front();
      ex_den = 1; ex_d = e.d; ex_ce = e.ce; ex_ps = e.ps; ex_un = e.un;
    end else begin
      ex_den = 0; ex_ce = 0; ex_ps = 0; ex_un = 0;
    end
  endtask

  task automatic compare();
    string m = ser_mode ? "R8" : "R2";
    chk({"den ", m, " ", tag}, ts_den, ex_den);
    chk({"ce ", m, " ", tag}, ts_ce, ex_ce);
    chk({"psync ", ser_mode ? "R4" : "R3", " ", tag}, ts_psync, ex_ps);
    chk({"uncor R5 ", tag}, ts_uncor, ex_un);
    if (ex_den) chk({"data R1 ", tag}, ts_data, ex_d);
    chk({"ready R9 ", tag}, in_ready, ser_mode ? (q.size() == 0) : 1);
  endtask

  task automatic cyc(output bit acc);
    logic [7:0] d; bit s, u;
    #1;
    acc = in_valid && in_ready;
    d = in_data; s = in_sop; u = in_uncor;
    @(posedge clk);
    model(acc, d, s, u);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    bit a;
    in_valid = 0;
    for (int i = 0; i < n; i++) cyc(a);
  endtask

  task automatic put(logic [7:0] d, bit sop, bit unc, int gap);
    bit a;
    in_valid = 1; in_data = d; in_sop = sop; in_uncor = unc;
    a = 0;
    while (!a) cyc(a);
    in_valid = 0; in_sop = 0; in_uncor = 0;
    if (gap > 0) idle(gap);
  endtask

  task automatic pkt(int len, bit unc, int seed, int gap);
    for (int i = 0; i < len; i++)
      put(i == 0 ? 8'h47 : 8'((seed + i * 29) & 255), i == 0, unc, gap);
  endtask

  task automatic do_reset(bit mode);
    in_valid = 0; rst = 1; ser_mode = mode;
    repeat (3) @(negedge clk);
    chk("reset R11 den", ts_den, 0);
    chk("reset R11 ce", ts_ce, 0);
    chk("reset R11 psync", ts_psync, 0);
    chk("reset R11 uncor", ts_uncor, 0);
    chk("reset R11 ready", in_ready, 1);
    rst = 0;
    q.delete(); m_idx = PKT - 1; m_unc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset(0);
    tag = "R11"; idle(1);
    // parallel mode
    tag = "R10 nosync"; put(8'h11, 0, 1, 0); put(8'h22, 0, 1, 0);
    tag = "R3";  pkt(PKT, 0, 5, 0);
    tag = "R2";  pkt(10, 0, 9, 1);
    tag = "R6";  pkt(20, 1, 3, 0); pkt(20, 1, 200, 0);
    tag = "R7";  tei_off = 1; pkt(20, 1, 3, 0); tei_off = 0;
    tag = "R10"; pkt(1, 1, 3, 0); pkt(2, 0, 3, 0); pkt(2, 1, 3, 0);
    pkt(1, 0, 3, 0); pkt(3, 1, 3, 0);
    tag = "R10 long"; pkt(PKT + 5, 1, 3, 0);
    idle(3);
    // serial mode
    do_reset(1);
    tag = "R11"; idle(1);
    tag = "R8";  pkt(6, 0, 3, 0);
    tag = "R4";  pkt(4, 0, 77, 3);
    tag = "R6";  pkt(6, 1, 3, 0);
    tag = "R7";  tei_off = 1; pkt(6, 1, 3, 0); tei_off = 0;
    tag = "R9";  pkt(1, 1, 3, 0); pkt(2, 0, 3, 0); pkt(2, 1, 3, 2);
    tag = "R1";  pkt(3, 0, 150, 1);
    idle(20);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule